// File: doc/BRIEF.md
# JTAG User-Chain Virtual Instruction Hub

The hub sits between a standard boundary-scan TAP controller and a set of on-chip debug nodes, so that many nodes can share the two user-defined JTAG instructions. The hub runs on the test clock. It watches the TAP's current state and the instruction the TAP has loaded. When the virtual-instruction opcode is loaded, each data-register scan carries a node address together with an instruction value. On Update-DR the hub stores the address as the active node and writes the value into that node's virtual instruction register. These registers sit in the hub and drive the nodes in parallel.

When the virtual-data opcode is loaded, the hub asserts the enable of the active node only. It sends TDI to every node and returns TDO from the active node's serial output. If the active address names no attached node, a one-bit bypass register takes the node's place. The hub also decodes the TAP state into single-cycle strobes that every node shares, so each node can run its own capture, shift and update.

A capture under the virtual-instruction opcode loads the active address and that node's stored instruction value. A host can therefore read back the current setting in the same scan that writes the next one.

Top module: `vjh_top`

## Requirements
- R1: The hub acts on two physical instruction codes only: 10'b00_0000_1100 selects the virtual data path and 10'b00_0000_1110 selects the virtual instruction path. Under any other code, tdo is 0, every node enable is low and no stored value changes.
- R2: Under the virtual-instruction code, the chain is ADDR_W+VIR_W bits long and shifts LSB first from tdi. The address occupies the upper ADDR_W bits and the instruction value the lower VIR_W bits. tdo shows chain bit 0. On Update-DR the value is written into slot `address` of vir_out, at bits [address*VIR_W +: VIR_W].
- R3: The active address changes only on Update-DR under the virtual-instruction code, or on test-logic-reset. It keeps its value through any number of virtual-data scans.
- R4: Capture-DR under the virtual-instruction code loads {active address, stored value of the active node} into the chain. The stored value reads as 0 when the active address is out of range.
- R5: While the virtual-data code is loaded, node_en is one-hot on the active node and tdo equals node_so of that node. node_si always equals tdi.
- R6: An active address of NODES or above selects no node. No instruction value is written for it, node_en is all zero, and tdo comes from a one-bit bypass register. That register is cleared on Capture-DR and loaded from tdi on each Shift-DR edge.
- R7: The state input is encoded 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. Each strobe output (cdr, sdr, e1dr, e2dr, pdr, udr, e1ir, uir) is high exactly while the state equals its own code.
- R8: A low rst_n, or any clock edge in the reset state (code 0), clears every stored instruction value, the active address and the chain.
- R9: The chain moves only on edges in shift-DR. Pause and exit states hold it, so a scan split by a pause gives the same result as an unbroken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ir_value | input | 10 | Instruction currently loaded in the TAP |
| tap_state | input | 4 | Current TAP state, encoded as in R7 |
| tdi | input | 1 | Serial data from the TAP |
| node_so | input | NODES | Serial outputs of the nodes' data registers |
| tdo | output | 1 | Serial data back to the TAP |
| node_si | output | 1 | Serial input shared by all nodes |
| node_en | output | NODES | Per-node enable, virtual data path |
| vir_out | output | NODES*VIR_W | Stored instruction value of every node |
| st_cdr | output | 1 | Capture-DR strobe |
| st_sdr | output | 1 | Shift-DR strobe |
| st_e1dr | output | 1 | Exit1-DR strobe |
| st_e2dr | output | 1 | Exit2-DR strobe |
| st_pdr | output | 1 | Pause-DR strobe |
| st_udr | output | 1 | Update-DR strobe |
| st_e1ir | output | 1 | Exit1-IR strobe |
| st_uir | output | 1 | Update-IR strobe |

## Verification
The properties assume that tap_state follows a legal TAP walk and that ir_value changes only outside data-register scans, as a real TAP controller guarantees. The bench drives state and instruction only on falling clock edges and always follows capture, shift, exit, update order. Any change of instruction happens while the TAP is idle, so every edge sees a consistent state and instruction pair.

// File: rtl/vjh_pkg.sv
package vjh_pkg;

    localparam int IR_W = 10;

    // physical opcodes the hub responds to
    localparam logic [IR_W-1:0] IR_VDR = 10'b00_0000_1100;
    localparam logic [IR_W-1:0] IR_VIR = 10'b00_0000_1110;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_E1_DR  = 4'd5,
        ST_P_DR   = 4'd6,
        ST_E2_DR  = 4'd7,
        ST_UP_DR  = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_E1_IR  = 4'd12,
        ST_P_IR   = 4'd13,
        ST_E2_IR  = 4'd14,
        ST_UP_IR  = 4'd15
    } tap_st_e;

endpackage

// File: rtl/vjh_tap_decode.sv
module vjh_tap_decode
    import vjh_pkg::*;
(
    input  logic [3:0]      tap_state,
    input  logic [IR_W-1:0] ir_value,
    output logic            is_vdr,
    output logic            is_vir,
    output logic            in_reset,
    output logic            st_cdr,
    output logic            st_sdr,
    output logic            st_e1dr,
    output logic            st_e2dr,
    output logic            st_pdr,
    output logic            st_udr,
    output logic            st_e1ir,
    output logic            st_uir
);

    always_comb begin
        is_vdr   = (ir_value == IR_VDR);
        is_vir   = (ir_value == IR_VIR);
        in_reset = (tap_state == ST_RESET);
        st_cdr   = (tap_state == ST_CAP_DR);
        st_sdr   = (tap_state == ST_SH_DR);
        st_e1dr  = (tap_state == ST_E1_DR);
        st_e2dr  = (tap_state == ST_E2_DR);
        st_pdr   = (tap_state == ST_P_DR);
        st_udr   = (tap_state == ST_UP_DR);
        st_e1ir  = (tap_state == ST_E1_IR);
        st_uir   = (tap_state == ST_UP_IR);
    end

endmodule

// File: rtl/vjh_vir_chain.sv
module vjh_vir_chain #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    parameter int VIR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tdi,
    input  logic                     sel,
    input  logic                     cap,
    input  logic                     sh,
    input  logic                     up,
    input  logic                     clr,
    output logic                     chain_lsb,
    output logic [ADDR_W-1:0]        active_addr,
    output logic                     addr_valid,
    output logic [NODES*VIR_W-1:0]   vir_flat
);

    localparam int CHAIN_W = ADDR_W + VIR_W;
    localparam logic [ADDR_W:0] NODES_L = (ADDR_W+1)'(NODES);

    typedef struct packed {
        logic [CHAIN_W-1:0]               sr;
        logic [ADDR_W-1:0]                addr;
        logic [NODES-1:0][VIR_W-1:0]      vir;
    } chain_st_t;

    chain_st_t st_d, st_q;

    logic [VIR_W-1:0]  cur_vir;
    logic [ADDR_W-1:0] new_addr;
    logic [VIR_W-1:0]  new_vir;

    // value held for the active node (zero when no node matches)
    always_comb begin
        cur_vir = '0;
        for (int i = 0; i < NODES; i++) begin
            if (st_q.addr == ADDR_W'(i)) cur_vir = st_q.vir[i];
        end
    end

    assign new_addr = st_q.sr[CHAIN_W-1:VIR_W];
    assign new_vir  = st_q.sr[VIR_W-1:0];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (sel) begin
            if (cap) begin
                st_d.sr = {st_q.addr, cur_vir};
            end else if (sh) begin
                st_d.sr = {tdi, st_q.sr[CHAIN_W-1:1]};
            end else if (up) begin
                st_d.addr = new_addr;
                for (int i = 0; i < NODES; i++) begin
                    if (new_addr == ADDR_W'(i)) st_d.vir[i] = new_vir;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_lsb   = st_q.sr[0];
    assign active_addr = st_q.addr;
    assign addr_valid  = ({1'b0, st_q.addr} < NODES_L);
    assign vir_flat    = st_q.vir;

endmodule

// File: rtl/vjh_vdr_route.sv
module vjh_vdr_route #(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              sel,
    input  logic              cap,
    input  logic              sh,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  logic [NODES-1:0]  node_so,
    output logic [NODES-1:0]  node_en,
    output logic              tdo_vdr
);

    logic byp_d, byp_q;
    logic picked;

    // one enable per node, only under the data opcode
    for (genvar g = 0; g < NODES; g++) begin : g_en
        assign node_en[g] = sel && (addr == ADDR_W'(g));
    end

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (addr == ADDR_W'(i)) picked = node_so[i];
        end
    end

    always_comb begin
        byp_d = byp_q;
        if (clr) begin
            byp_d = 1'b0;
        end else if (sel && !addr_valid) begin
            if (cap)     byp_d = 1'b0;
            else if (sh) byp_d = tdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= byp_d;
    end

    assign tdo_vdr = addr_valid ? picked : byp_q;

endmodule

// File: rtl/vjh_top.sv
module vjh_top
    import vjh_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    parameter int VIR_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [9:0]             ir_value,
    input  logic [3:0]             tap_state,
    input  logic                   tdi,
    input  logic [NODES-1:0]       node_so,
    output logic                   tdo,
    output logic                   node_si,
    output logic [NODES-1:0]       node_en,
    output logic [NODES*VIR_W-1:0] vir_out,
    output logic                   st_cdr,
    output logic                   st_sdr,
    output logic                   st_e1dr,
    output logic                   st_e2dr,
    output logic                   st_pdr,
    output logic                   st_udr,
    output logic                   st_e1ir,
    output logic                   st_uir
);

    logic              is_vdr, is_vir, in_reset;
    logic              chain_lsb, addr_valid, tdo_vdr;
    logic [ADDR_W-1:0] active_addr;

    vjh_tap_decode u_dec (
        .tap_state (tap_state),
        .ir_value  (ir_value),
        .is_vdr    (is_vdr),
        .is_vir    (is_vir),
        .in_reset  (in_reset),
        .st_cdr    (st_cdr),
        .st_sdr    (st_sdr),
        .st_e1dr   (st_e1dr),
        .st_e2dr   (st_e2dr),
        .st_pdr    (st_pdr),
        .st_udr    (st_udr),
        .st_e1ir   (st_e1ir),
        .st_uir    (st_uir)
    );

    vjh_vir_chain #(.NODES(NODES), .ADDR_W(ADDR_W), .VIR_W(VIR_W)) u_vir (
        .clk         (clk),
        .rst_n       (rst_n),
        .tdi         (tdi),
        .sel         (is_vir),
        .cap         (st_cdr),
        .sh          (st_sdr),
        .up          (st_udr),
        .clr         (in_reset),
        .chain_lsb   (chain_lsb),
        .active_addr (active_addr),
        .addr_valid  (addr_valid),
        .vir_flat    (vir_out)
    );

    vjh_vdr_route #(.NODES(NODES), .ADDR_W(ADDR_W)) u_vdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .sel        (is_vdr),
        .cap        (st_cdr),
        .sh         (st_sdr),
        .clr        (in_reset),
        .addr       (active_addr),
        .addr_valid (addr_valid),
        .node_so    (node_so),
        .node_en    (node_en),
        .tdo_vdr    (tdo_vdr)
    );

    assign node_si = tdi;

    always_comb begin
        if (is_vir)      tdo = chain_lsb;
        else if (is_vdr) tdo = tdo_vdr;
        else             tdo = 1'b0;
    end

endmodule

// File: rtl/vjh_checker.sv
module vjh_checker
    import vjh_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int ADDR_W = 3,
    parameter int VIR_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             tap_state,
    input logic [9:0]             ir_value,
    input logic [NODES-1:0]       node_en,
    input logic                   tdo,
    input logic [NODES*VIR_W-1:0] vir_out,
    input logic [ADDR_W-1:0]      active_addr,
    input logic [7:0]             strobes
);

    localparam logic [ADDR_W:0] NODES_L = (ADDR_W+1)'(NODES);

    logic vir_upd, foreign_ir, addr_oob;
    assign vir_upd    = (tap_state == ST_UP_DR) && (ir_value == IR_VIR);
    assign foreign_ir = (ir_value != IR_VIR) && (ir_value != IR_VDR);
    assign addr_oob   = !({1'b0, active_addr} < NODES_L);

    // R1: foreign opcode leaves tdo quiet and no node enabled
    a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_ir |-> (tdo == 1'b0 && node_en == '0));

    // R2: stored values move only on a virtual-instruction update or reset
    a_r2_vir_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!vir_upd && tap_state != ST_RESET) |=> $stable(vir_out));

    // R3: active address held outside its update
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vir_upd && tap_state != ST_RESET) |=> $stable(active_addr));

    // R5: at most one node enabled
    a_r5_en_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(node_en));

    // R6: out-of-range address enables nothing
    a_r6_oob_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oob |-> (node_en == '0));

    // R6: update to an out-of-range address writes no value
    a_r6_oob_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        vir_upd |=> (!addr_oob || vir_out == $past(vir_out)));

    // R7: at most one state strobe at a time
    a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    // R8: reset state clears stored values and address
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_state == ST_RESET) |=> (vir_out == '0 && active_addr == '0));

endmodule

bind vjh_top vjh_checker #(.NODES(NODES), .ADDR_W(ADDR_W), .VIR_W(VIR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_state   (tap_state),
    .ir_value    (ir_value),
    .node_en     (node_en),
    .tdo         (tdo),
    .vir_out     (vir_out),
    .active_addr (active_addr),
    .strobes     ({st_cdr, st_sdr, st_e1dr, st_e2dr, st_pdr, st_udr, st_e1ir, st_uir})
);

// File: tb/sim_vjh_top.sv
`timescale 1ns/1ps
module sim_vjh_top;

    localparam int NODES  = 4;
    localparam int ADDR_W = 3;
    localparam int VIR_W  = 4;
    localparam int CW     = ADDR_W + VIR_W;
    localparam logic [9:0] OP_VDR = 10'b00_0000_1100;
    localparam logic [9:0] OP_VIR = 10'b00_0000_1110;
    localparam logic [9:0] OP_BYP = 10'b11_1111_1111;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [9:0]             ir_value = '0;
    logic [3:0]             tap_state = 4'd0;
    logic                   tdi = 1'b0;
    logic [NODES-1:0]       node_so;
    logic                   tdo, node_si;
    logic [NODES-1:0]       node_en;
    logic [NODES*VIR_W-1:0] vir_out;
    logic st_cdr, st_sdr, st_e1dr, st_e2dr, st_pdr, st_udr, st_e1ir, st_uir;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    vjh_top #(.NODES(NODES), .ADDR_W(ADDR_W), .VIR_W(VIR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .tap_state(tap_state),
        .tdi(tdi), .node_so(node_so), .tdo(tdo), .node_si(node_si),
        .node_en(node_en), .vir_out(vir_out),
        .st_cdr(st_cdr), .st_sdr(st_sdr), .st_e1dr(st_e1dr), .st_e2dr(st_e2dr),
        .st_pdr(st_pdr), .st_udr(st_udr), .st_e1ir(st_e1ir), .st_uir(st_uir)
    );

    // bench-side node data registers, 8 bits each
    logic [7:0] nreg [NODES];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NODES; i++) nreg[i] <= 8'hA0 + 8'(i);
        end else begin
            for (int i = 0; i < NODES; i++)
                if (node_en[i] && st_sdr) nreg[i] <= {node_si, nreg[i][7:1]};
        end
    end
    always_comb for (int i = 0; i < NODES; i++) node_so[i] = nreg[i][0];

    // address/value pairs walked by the main loop: {addr[2:0], value[3:0]}
    localparam logic [6:0] VEC [10] = '{
        {3'd1, 4'h5}, {3'd2, 4'hA}, {3'd0, 4'hF}, {3'd3, 4'h3}, {3'd6, 4'h7},
        {3'd1, 4'hC}, {3'd5, 4'h1}, {3'd0, 4'h0}, {3'd2, 4'h6}, {3'd3, 4'h9}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] s, input logic t);
        @(negedge clk);
        tap_state = s;
        tdi = t;
        #1;
    endtask

    // capture, shift n bits (optional pause before bit pause_at), exit, update, idle
    task automatic scan(input logic [15:0] din, input int n, input int pause_at,
                        output logic [15:0] dout, output logic [NODES-1:0] en_seen);
        dout = '0;
        step(4'd3, 1'b0);
        for (int k = 0; k < n; k++) begin
            if (k == pause_at && k > 0) begin
                step(4'd5, 1'b0);
                step(4'd6, 1'b0);
                step(4'd6, 1'b0);
                step(4'd7, 1'b0);
            end
            step(4'd4, din[k]);
            dout[k] = tdo;
            if (k == 0) en_seen = node_en;
        end
        step(4'd5, 1'b0);
        step(4'd8, 1'b0);
        step(4'd1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] dout;
        logic [NODES-1:0] en;
        logic [15:0] mvir;
        logic [2:0]  maddr;
        logic [3:0]  expv;
        logic [7:0]  exps;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        check(vir_out == '0, "R8 reset values", 32'(vir_out), 0);
        check(node_en == '0 && tdo == 1'b0, "R8 reset outputs", {node_en, 3'b0, tdo}, 0);

        // R7: strobes against every state code, foreign opcode loaded
        ir_value = OP_BYP;
        for (int s = 0; s < 16; s++) begin
            step(4'(s), 1'b0);
            exps = {s == 3, s == 4, s == 5, s == 7, s == 6, s == 8, s == 12, s == 15};
            check({st_cdr, st_sdr, st_e1dr, st_e2dr, st_pdr, st_udr, st_e1ir, st_uir} == exps,
                  "R7 strobes", {st_cdr, st_sdr, st_e1dr, st_e2dr, st_pdr, st_udr, st_e1ir, st_uir}, exps);
        end
        step(4'd1, 1'b0);

        // R1: foreign opcode scan changes nothing, tdo quiet
        scan(16'h007F, CW, -1, dout, en);
        check(dout == '0, "R1 tdo quiet", dout, 0);
        check(en == '0, "R1 no enable", 32'(en), 0);
        check(vir_out == '0, "R1 no write", 32'(vir_out), 0);

        // R2 R4 R6 R9: vector walk; each scan reads back the previous setting
        ir_value = OP_VIR;
        step(4'd1, 1'b0);
        mvir  = '0;
        maddr = '0;
        for (int v = 0; v < 10; v++) begin
            expv = (maddr < 3'(NODES)) ? mvir[maddr*4 +: 4] : 4'h0;
            scan(16'(VEC[v]), CW, (v == 3) ? 3 : -1, dout, en);
            check(dout[6:0] == {maddr, expv}, (v == 3) ? "R9 paused readback" : "R4 readback",
                  dout, {maddr, expv});
            maddr = VEC[v][6:4];
            if (maddr < 3'(NODES)) mvir[maddr*4 +: 4] = VEC[v][3:0];
            check(vir_out == mvir, (maddr < 3'(NODES)) ? "R2 value write" : "R6 no write",
                  32'(vir_out), 32'(mvir));
        end

        // R5 R3: data path to node 3 (active from last vector)
        ir_value = OP_VDR;
        step(4'd1, 1'b0);
        scan(16'h005A, 8, -1, dout, en);
        check(en == 4'b1000, "R5 enable one-hot", 32'(en), 32'h8);
        check(dout[7:0] == 8'hA3, "R5 node data", dout, 32'hA3);
        scan(16'h0000, 8, 4, dout, en);
        check(dout[7:0] == 8'h5A, "R5 node data second scan", dout, 32'h5A);

        // R3: address still 3 after data scans
        ir_value = OP_VIR;
        step(4'd1, 1'b0);
        scan(16'(7'h70), CW, -1, dout, en);
        check(dout[6:0] == {3'd3, 4'h9}, "R3 address held", dout, {3'd3, 4'h9});

        // R6: address 7 now active, bypass on the data path
        ir_value = OP_VDR;
        step(4'd1, 1'b0);
        scan(16'h00B6, 8, -1, dout, en);
        check(en == '0, "R6 no enable", 32'(en), 0);
        check(dout[7:0] == 8'h6C, "R6 bypass delay", dout, 32'h6C);
        check(vir_out == mvir, "R6 values kept", 32'(vir_out), 32'(mvir));

        // R8: reset state clears, readback gives zero address
        step(4'd0, 1'b0);
        step(4'd1, 1'b0);
        check(vir_out == '0, "R8 reset state clears", 32'(vir_out), 0);
        ir_value = OP_VIR;
        step(4'd1, 1'b0);
        scan(16'h0000, CW, -1, dout, en);
        check(dout[6:0] == '0, "R8 address cleared", dout, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule